// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between the command generator of an SDRAM controller and the memory command bus. It sees one pending request at a time, made of a command code and a bank number. It raises a grant in the same cycle as the request once every interval rule for that command holds. Until then the requester keeps the request asserted. The guard tracks four banks by default. For each bank it keeps the row state, a running age since the last activation, and the recovery windows that a write opens. It also tracks the spacing rules that apply across banks.

A static parameter selects a 7.5 ns or a 10 ns clock period. All limits given in nanoseconds become clock counts at elaboration: the limit is divided by the period and rounded up to the next whole cycle. Requests that can never become legal are refused at once with an illegal pulse. Such requests are a column access to a closed bank, or an activation of a bank that already has a row open. For each bank, a flag reports that a row has stayed open for the maximum allowed time and must be precharged.

Top module: `sdr_cmd_guard`

## Requirements
- R1: Out of reset, grant, illegal and every must-precharge flag are low and all banks are closed. A valid legal request is granted combinationally in the same cycle, and a request that is not yet legal is granted in the first cycle in which it becomes legal.
- R2: Command encoding on req_cmd: 1 = activate, 2 = read, 3 = write, 4 = precharge, 5 = burst stop. Codes 0, 6 and 7 are never granted and never raise illegal.
- R3: Two activations, whether to different banks or to any banks, are granted at least ceil(15 ns / tCK) cycles apart (ceil(20 ns / tCK) when the 10 ns period is selected).
- R4: A read or write to a bank is granted no sooner than ceil(20 ns / tCK) cycles after that bank's activation. An activation is granted no sooner than ceil(20 ns / tCK) cycles after a precharge of the same bank.
- R5: A precharge of an open bank is granted no sooner than ceil(45 ns / tCK) cycles after its activation (50 ns with the 10 ns period).
- R6: Activations of the same bank are at least ceil(65 ns / tCK) cycles apart (70 ns with the 10 ns period).
- R7: A write's last data beat falls BURST_LEN-1 cycles after the write. A precharge of the written bank waits BURST_LEN-1+2 cycles after the write. An activation of that bank waits BURST_LEN-1+2+ceil(20 ns / tCK) cycles after the write.
- R8: After a write, the next read or write to any bank waits BURST_LEN cycles, and a burst stop also waits BURST_LEN cycles. After a read, column commands may be granted on consecutive cycles. Burst stop ignores the bank field.
- R9: A read or write to a closed bank, or an activation of an open bank, sets illegal in the same cycle and is not granted. Such a request leaves all bank state unchanged.
- R10: Take an activation granted in cycle t. The bank's must-precharge flag rises in cycle t + ceil(100 us / tCK) if no precharge intervenes. It stays high until a precharge of that bank is granted, and it is low in the cycle after that grant.
- R11: A precharge of a closed bank is granted at once and restarts that bank's precharge wait of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 3 | Command code, encoding per R2 |
| req_bank | input | clog2(NUM_BANKS) | Target bank |
| grant | output | 1 | Request accepted this cycle |
| illegal | output | 1 | Request can never be legal in the current state |
| row_overdue | output | NUM_BANKS | Per-bank must-precharge flag |

## Verification
Grant and illegal are combinational, so each is sampled in the cycle its request is presented. Every interval is measured from the bench's cycle number of the earlier grant. The expected grant cycle is the larger of the presentation cycle and each applicable earlier grant plus its rounded rule count. Every register on the path, whether a countdown timer or the age counter, is loaded at the edge that closes the granting cycle. The must-precharge flag therefore appears exactly the limit count of cycles after the activation, and the bench samples it one cycle before that point and at that point. All sampling happens at the falling clock edge, after inputs were driven at the previous falling edge and given time to settle.

// File: rtl/sdr_guard_pkg.sv
package sdr_guard_pkg;

   typedef enum logic [2:0] {
      CMD_NONE = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_BST  = 3'd5
   } sdr_cmd_e;

   // Minimum whole clock count covering a time span (both in picoseconds).
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Bits needed to hold the value v (at least one).
   function automatic int width_for(input int v);
      int w;
      w = 1;
      while ((64'(1) << w) <= 64'(v)) w++;
      return w;
   endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer
   import sdr_guard_pkg::*;
#(
   parameter int LOADV = 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic done
);

   generate
      if (LOADV <= 0) begin : g_none
         logic unused_pins;
         assign unused_pins = ^{clk, rst_n, fire};
         assign done = 1'b1;
      end else begin : g_count
         localparam int W = width_for(LOADV);
         localparam logic [W-1:0] LOAD_V = W'(LOADV);
         logic [W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (fire) begin
               cnt_q <= LOAD_V;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign done = (cnt_q == '0);

         AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> !done); // R4
      end
   endgenerate

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
   import sdr_guard_pkg::*;
#(
   parameter int RCD_C    = 3,
   parameter int RAS_C    = 6,
   parameter int RC_C     = 9,
   parameter int RP_C     = 3,
   parameter int WPRE_C   = 3,
   parameter int WACT_C   = 6,
   parameter int RASMAX_C = 13334
)(
   input  logic clk,
   input  logic rst_n,
   input  logic act_go,
   input  logic col_go,
   input  logic wr_go,
   input  logic pre_go,
   output logic is_open,
   output logic can_act,
   output logic can_col,
   output logic can_pre,
   output logic overdue
);

   localparam int AGE_TOP = imax(RASMAX_C, RC_C);
   localparam int AW      = width_for(AGE_TOP);
   localparam logic [AW-1:0] TOP_V    = AW'(AGE_TOP);
   localparam logic [AW-1:0] RCD_V    = AW'(RCD_C);
   localparam logic [AW-1:0] RAS_V    = AW'(RAS_C);
   localparam logic [AW-1:0] RC_V     = AW'(RC_C);
   localparam logic [AW-1:0] RASMAX_V = AW'(RASMAX_C);

   logic          open_q;
   logic [AW-1:0] age_q;
   logic          rp_done;
   logic          wpre_done;
   logic          wact_done;

   // Row state and a saturating age counter shared by every same-bank window.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         age_q  <= TOP_V;
      end else begin
         if (act_go) begin
            open_q <= 1'b1;
         end else if (pre_go) begin
            open_q <= 1'b0;
         end
         if (act_go) begin
            age_q <= AW'(1);
         end else if (age_q != TOP_V) begin
            age_q <= age_q + 1'b1;
         end
      end
   end

   sdr_gap_timer #(.LOADV(RP_C - 1)) u_rp (
      .clk(clk), .rst_n(rst_n), .fire(pre_go), .done(rp_done));

   sdr_gap_timer #(.LOADV(WPRE_C - 1)) u_wpre (
      .clk(clk), .rst_n(rst_n), .fire(wr_go), .done(wpre_done));

   sdr_gap_timer #(.LOADV(WACT_C - 1)) u_wact (
      .clk(clk), .rst_n(rst_n), .fire(wr_go), .done(wact_done));

   assign is_open = open_q;
   assign can_act = !open_q && (age_q >= RC_V) && rp_done && wact_done;
   assign can_col = open_q && (age_q >= RCD_V);
   assign can_pre = !open_q || ((age_q >= RAS_V) && wpre_done);
   assign overdue = open_q && (age_q >= RASMAX_V);

   AST_ACT_NEEDS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      act_go |-> !open_q); // R9
   AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      col_go |-> open_q); // R9
   AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_go && open_q) |-> (age_q >= RAS_V)); // R5
   AST_OVERDUE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overdue && !pre_go) |=> overdue); // R10
   AST_PRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      pre_go |=> !overdue); // R10

endmodule

// File: rtl/sdr_cmd_guard.sv
module sdr_cmd_guard
   import sdr_guard_pkg::*;
#(
   parameter int CLK_SEL   = 0,
   parameter int NUM_BANKS = 4,
   parameter int BURST_LEN = 2,
   localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [2:0]           req_cmd,
   input  logic [BA_W-1:0]      req_bank,
   output logic                 grant,
   output logic                 illegal,
   output logic [NUM_BANKS-1:0] row_overdue
);

   // Clock-count limits derived from the selected period (picoseconds).
   localparam int PER_PS   = (CLK_SEL == 1) ? 10000 : 7500;
   localparam int RRD_C    = ceil_div((CLK_SEL == 1) ? 20000 : 15000, PER_PS);
   localparam int RCD_C    = ceil_div(20000, PER_PS);
   localparam int RP_C     = ceil_div(20000, PER_PS);
   localparam int RAS_C    = ceil_div((CLK_SEL == 1) ? 50000 : 45000, PER_PS);
   localparam int RC_C     = ceil_div((CLK_SEL == 1) ? 70000 : 65000, PER_PS);
   localparam int RASMAX_C = ceil_div(100_000_000, PER_PS);
   localparam int LAST_OFS = BURST_LEN - 1;
   localparam int WPRE_C   = LAST_OFS + 2;
   localparam int WACT_C   = LAST_OFS + 2 + ceil_div(20000, PER_PS);
   localparam int WCOL_C   = LAST_OFS + 1;
   localparam int WBST_C   = LAST_OFS + 1;

   // Elaboration-time parameter checks.
   generate
      if (CLK_SEL != 0 && CLK_SEL != 1) begin : g_bad_sel
         $error("CLK_SEL must be 0 (7.5 ns) or 1 (10 ns)");
      end
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (BURST_LEN < 1) begin : g_bad_bl
         $error("BURST_LEN must be at least 1");
      end
   endgenerate

   sdr_cmd_e cmd;
   assign cmd = sdr_cmd_e'(req_cmd);

   logic [NUM_BANKS-1:0] bank_sel;
   logic [NUM_BANKS-1:0] b_open, b_can_act, b_can_col, b_can_pre;
   logic [NUM_BANKS-1:0] act_go, col_go, wr_go, pre_go;
   logic rrd_done, wcol_done, wbst_done;
   logic cmd_ok, cmd_bad;

   // Cross-bank windows.
   sdr_gap_timer #(.LOADV(RRD_C - 1)) u_rrd (
      .clk(clk), .rst_n(rst_n), .fire(grant && cmd == CMD_ACT), .done(rrd_done));

   sdr_gap_timer #(.LOADV(WCOL_C - 1)) u_wcol (
      .clk(clk), .rst_n(rst_n), .fire(grant && cmd == CMD_WR), .done(wcol_done));

   sdr_gap_timer #(.LOADV(WBST_C - 1)) u_wbst (
      .clk(clk), .rst_n(rst_n), .fire(grant && cmd == CMD_WR), .done(wbst_done));

   // Per-bank trackers.
   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign bank_sel[b] = (req_bank == BA_W'(b));
         assign act_go[b] = grant && bank_sel[b] && (cmd == CMD_ACT);
         assign wr_go[b]  = grant && bank_sel[b] && (cmd == CMD_WR);
         assign col_go[b] = grant && bank_sel[b] && (cmd == CMD_RD || cmd == CMD_WR);
         assign pre_go[b] = grant && bank_sel[b] && (cmd == CMD_PRE);

         sdr_bank_track #(
            .RCD_C(RCD_C), .RAS_C(RAS_C), .RC_C(RC_C), .RP_C(RP_C),
            .WPRE_C(WPRE_C), .WACT_C(WACT_C), .RASMAX_C(RASMAX_C)
         ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_go(act_go[b]), .col_go(col_go[b]), .wr_go(wr_go[b]), .pre_go(pre_go[b]),
            .is_open(b_open[b]), .can_act(b_can_act[b]), .can_col(b_can_col[b]),
            .can_pre(b_can_pre[b]), .overdue(row_overdue[b]));
      end
   endgenerate

   // Decision for the presented command.
   always_comb begin
      cmd_ok  = 1'b0;
      cmd_bad = 1'b0;
      unique case (cmd)
         CMD_ACT: begin
            cmd_bad = b_open[req_bank];
            cmd_ok  = b_can_act[req_bank] && rrd_done;
         end
         CMD_RD, CMD_WR: begin
            cmd_bad = !b_open[req_bank];
            cmd_ok  = b_can_col[req_bank] && wcol_done;
         end
         CMD_PRE: cmd_ok = b_can_pre[req_bank];
         CMD_BST: cmd_ok = wbst_done;
         default: begin
            cmd_ok  = 1'b0;
            cmd_bad = 1'b0;
         end
      endcase
   end

   assign grant   = req_valid && cmd_ok && !cmd_bad;
   assign illegal = req_valid && cmd_bad;

   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> req_valid); // R1
   AST_GRANT_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && illegal)); // R9
   AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_BST}))
      |-> (!grant && !illegal)); // R2

   generate
      if (RRD_C >= 2) begin : g_rrd_chk
         AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (grant && cmd == CMD_ACT) |=> !(grant && cmd == CMD_ACT)); // R3
      end
      if (WCOL_C >= 2) begin : g_wcol_chk
         AST_WR_COL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (grant && cmd == CMD_WR) |=> !(grant && (cmd == CMD_RD || cmd == CMD_WR))); // R8
      end
   endgenerate

endmodule

// File: tb/tb_sdr_cmd_guard.sv
`timescale 1ns/1ps
module tb_sdr_cmd_guard;

   localparam int CLK_SEL = 0;
   localparam int NB      = 4;
   localparam int BL      = 2;

   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int PER  = (CLK_SEL == 1) ? 10000 : 7500;
   localparam int T_RRD = cdiv((CLK_SEL == 1) ? 20000 : 15000, PER);
   localparam int T_RCD = cdiv(20000, PER);
   localparam int T_RP  = cdiv(20000, PER);
   localparam int T_RAS = cdiv((CLK_SEL == 1) ? 50000 : 45000, PER);
   localparam int T_RC  = cdiv((CLK_SEL == 1) ? 70000 : 65000, PER);
   localparam int T_MAX = cdiv(100_000_000, PER);
   localparam int T_WPRE = BL - 1 + 2;
   localparam int T_WACT = BL - 1 + 2 + cdiv(20000, PER);
   localparam int T_WCOL = BL;
   localparam int T_WBST = BL;

   localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4, C_BST = 3'd5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_cmd = 3'd0;
   logic [1:0]    req_bank = 2'd0;
   logic          grant;
   logic          illegal;
   logic [NB-1:0] row_overdue;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   sdr_cmd_guard #(.CLK_SEL(CLK_SEL), .NUM_BANKS(NB), .BURST_LEN(BL)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_bank(req_bank), .grant(grant), .illegal(illegal), .row_overdue(row_overdue));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Present a request, hold it until granted; return start and grant cycle.
   task automatic issue(input logic [2:0] c, input int b, output int s, output int g);
      @(negedge clk);
      req_valid = 1'b1;
      req_cmd   = c;
      req_bank  = b[1:0];
      s = cyc;
      g = -1;
      for (int k = 0; k < 300; k++) begin
         #1;
         if (grant) begin
            g = cyc;
            break;
         end
         @(negedge clk);
      end
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   // Present a request for one cycle only and report grant and illegal.
   task automatic probe(input logic [2:0] c, input int b, output int gr, output int il);
      @(negedge clk);
      req_valid = 1'b1;
      req_cmd   = c;
      req_bank  = b[1:0];
      #1;
      gr = int'(grant);
      il = int'(illegal);
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int s, g, gr, il;
      int a0, a1, a2, a3, w1, w2, p0, p3, last_act;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 reset grant", int'(grant), 0);
      chk("R1 reset illegal", int'(illegal), 0);
      chk("R1 reset overdue", int'(row_overdue), 0);

      // Mixed traffic on banks 0 and 1.
      issue(C_ACT, 0, s, g); a0 = g; last_act = g;
      chk("R1 immediate activate", g, s);
      issue(C_ACT, 1, s, g); a1 = g;
      chk("R3 activate spacing", g, mx(s, last_act + T_RRD)); last_act = g;
      issue(C_RD, 0, s, g);
      chk("R4 activate to read", g, mx(s, a0 + T_RCD));
      issue(C_RD, 0, s, g);
      chk("R8 back-to-back reads", g, s);
      issue(C_WR, 1, s, g); w1 = g;
      chk("R4 activate to write", g, mx(s, a1 + T_RCD));
      issue(C_RD, 0, s, g);
      chk("R8 write to column", g, mx(s, w1 + T_WCOL));
      issue(C_WR, 0, s, g); w2 = g;
      chk("R8 read to write", g, s);
      issue(C_BST, 3, s, g);
      chk("R8 write to burst stop", g, mx(s, w2 + T_WBST));
      issue(C_PRE, 1, s, g);
      chk("R7 write to precharge b1", g, mx(s, mx(a1 + T_RAS, w1 + T_WPRE)));
      issue(C_PRE, 0, s, g); p0 = g;
      chk("R7 write to precharge b0", g, mx(s, mx(a0 + T_RAS, w2 + T_WPRE)));
      issue(C_ACT, 0, s, g);
      chk("R6 R7 reactivate b0", g,
          mx(mx(s, p0 + T_RP), mx(mx(a0 + T_RC, w2 + T_WACT), last_act + T_RRD)));
      last_act = g;

      // Precharge of an idle bank, then activation.
      issue(C_PRE, 3, s, g); p3 = g;
      chk("R11 precharge idle bank", g, s);
      issue(C_ACT, 3, s, g); a3 = g;
      chk("R11 R4 precharge to activate", g, mx(mx(s, p3 + T_RP), last_act + T_RRD));
      last_act = g;

      // Row active minimum and same-bank cycle on bank 2.
      issue(C_ACT, 2, s, g); a2 = g;
      chk("R3 activate spacing b2", g, mx(s, last_act + T_RRD)); last_act = g;
      issue(C_PRE, 2, s, g);
      chk("R5 row active minimum", g, mx(s, a2 + T_RAS)); p0 = g;
      issue(C_ACT, 2, s, g);
      chk("R6 same-bank cycle", g, mx(mx(s, p0 + T_RP), mx(a2 + T_RC, last_act + T_RRD)));
      last_act = g;

      // Illegal requests.
      probe(C_RD, 1, gr, il);
      chk("R9 read closed bank grant", gr, 0);
      chk("R9 read closed bank illegal", il, 1);
      probe(C_WR, 1, gr, il);
      chk("R9 write closed bank illegal", il, 1);
      probe(C_ACT, 3, gr, il);
      chk("R9 activate open bank grant", gr, 0);
      chk("R9 activate open bank illegal", il, 1);

      // Unassigned codes.
      for (int c = 0; c < 8; c++) begin
         if (c == 0 || c == 6 || c == 7) begin
            probe(3'(c), 0, gr, il);
            chk("R2 unassigned code grant", gr, 0);
            chk("R2 unassigned code illegal", il, 0);
         end
      end

      // State unaffected by the refused requests.
      issue(C_RD, 3, s, g);
      chk("R9 bank 3 still open", g, mx(s, a3 + T_RCD));
      issue(C_ACT, 1, s, g); a1 = g;
      chk("R9 bank 1 still closed", g, mx(s, last_act + T_RRD));

      // Must-precharge flag on bank 1.
      while (cyc != a1 + T_MAX - 1) @(negedge clk);
      chk("R10 flag before limit", int'(row_overdue[1]), 0);
      @(negedge clk);
      chk("R10 flag at limit", int'(row_overdue[1]), 1);
      @(negedge clk);
      chk("R10 flag holds", int'(row_overdue[1]), 1);
      issue(C_PRE, 1, s, g);
      chk("R10 precharge of overdue row", g, s);
      @(negedge clk);
      chk("R10 flag cleared", int'(row_overdue[1]), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule